// File: doc/BRIEF.md
# Indexed Clock-Synthesizer Register Port

This block gives a host byte-wide access to a bank of 32 eight-bit configuration registers for a clock synthesizer. The registers are reached through an index byte and a data byte. The host first loads an index byte that carries the register number and a write flag. It then either drives a data byte, which is stored when the flag is set, or reads the selected register on the data output.

Beside the access port, a decoder reports the divider settings for one of four video clocks, picked by a 2-bit clock-select input. It reports the reference divider, that clock's feedback divider and its effective post-divide ratio. The 3-bit post code for the clock is gathered from two registers. It maps onto ratios that include 3, 6 and 12, and one code is invalid. A valid flag drops whenever the selected settings cannot produce a clock.

Top module: `clksynth_index_port`

## Requirements
- R1: After reset every register reads zero, the latched index is register 0 with the write flag clear, and `div_valid_o` is low.
- R2: A pulse on `idx_we_i` latches the index byte: bits 6:2 give the register number and bit 1 is the write flag. Bits 7 and 0 are ignored.
- R3: A pulse on `data_we_i` while the latched write flag is set stores `data_i` into the selected register. The new value is visible from the next cycle.
- R4: A pulse on `data_we_i` while the latched write flag is clear changes no register.
- R5: Loading an index byte with no data access leaves every register unchanged.
- R6: `data_o` always shows the register selected by the latched index.
- R7: `ref_div_o` equals register 2. `fb_div_o` equals register 7+k, where k is `vclk_sel_i`.
- R8: For clock k, the post code bits 1:0 are register 6 bits 2k+1:2k and code bit 2 is register 11 bit 4+k. No other bit of those registers affects the result.
- R9: Post codes 0 to 7 give `post_div_o` = 1, 2, 4, 8, 3, 0, 6 and 12 respectively. Code 5 is invalid and reports 0.
- R10: `div_valid_o` is high only when the post code is not 5 and register 2 is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_we_i | input | 1 | Load the index byte |
| idx_i | input | 8 | Index byte: register number in bits 6:2, write flag in bit 1 |
| data_we_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte to store |
| data_o | output | 8 | Contents of the selected register |
| vclk_sel_i | input | 2 | Video clock select |
| ref_div_o | output | 8 | Reference divider |
| fb_div_o | output | 8 | Feedback divider of the selected clock |
| post_div_o | output | 4 | Effective post-divide ratio, 0 when the code is invalid |
| div_valid_o | output | 1 | Divider settings usable |

## Verification
The assertions check on every cycle that a data strobe stores its byte into the addressed register and that the bank holds still when no store is enabled. They also check that the index holds between loads, and that a raised valid flag always comes with a nonzero reference divider and a legal ratio. Only the bench's scenarios can show the following: the bit positions of the post code for each clock, the full code-to-ratio table, and the rejected store when the write flag is clear. The bench sweeps all eight codes on all four clocks while the neighbouring fields hold unrelated values.

// File: rtl/clksynth_pkg.sv
package clksynth_pkg;
  localparam int REF_REG   = 2;
  localparam int POST_REG  = 6;
  localparam int FB_BASE   = 7;
  localparam int EXT_REG   = 11;
  localparam int EXT_SHIFT = 4;
  localparam int RATIO_W   = 4;

  // post code -> divide ratio; 0 marks the invalid code
  function automatic logic [RATIO_W-1:0] post_ratio(input logic [2:0] code);
    case (code)
      3'd0: post_ratio = 4'd1;
      3'd1: post_ratio = 4'd2;
      3'd2: post_ratio = 4'd4;
      3'd3: post_ratio = 4'd8;
      3'd4: post_ratio = 4'd3;
      3'd6: post_ratio = 4'd6;
      3'd7: post_ratio = 4'd12;
      default: post_ratio = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/clksynth_idx_reg.sv
module clksynth_idx_reg #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] byte_i,
  output logic [AW-1:0] sel_o,
  output logic          wr_en_o
);
  logic [AW-1:0] sel_q;
  logic          wr_q;
  logic          unused_bits;

  assign unused_bits = ^{byte_i[0], byte_i[DW-1:AW+2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      wr_q  <= 1'b0;
    end else if (load_i) begin
      sel_q <= byte_i[AW+1:2];
      wr_q  <= byte_i[1];
    end
  end

  assign sel_o   = sel_q;
  assign wr_en_o = wr_q;

  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable({sel_q, wr_q})); // R2
endmodule

// File: rtl/clksynth_bank.sv
module clksynth_bank #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int AW   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  logic [NREG-1:0][DW-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else if (we_i) regs_q[addr_i] <= wdata_i;
  end

  assign rdata_o = regs_q[addr_i];
  assign regs_o  = regs_q;

  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(addr_i)] == $past(wdata_i)); // R3
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q)); // R4
endmodule

// File: rtl/clksynth_post_decode.sv
module clksynth_post_decode
  import clksynth_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int AW   = 5
) (
  input  logic [NREG-1:0][DW-1:0] regs_i,
  input  logic [1:0]              vsel_i,
  output logic [DW-1:0]           ref_o,
  output logic [DW-1:0]           fb_o,
  output logic [RATIO_W-1:0]      post_o,
  output logic                    valid_o
);
  logic [AW-1:0] fb_idx;
  logic [2:0]    lo_pos;
  logic [2:0]    ext_pos;
  logic [2:0]    code;

  always_comb begin
    fb_idx  = AW'(FB_BASE) + AW'(vsel_i);
    lo_pos  = {vsel_i, 1'b0};
    ext_pos = 3'(EXT_SHIFT) + {1'b0, vsel_i};
    code    = {regs_i[EXT_REG][ext_pos], regs_i[POST_REG][lo_pos +: 2]};
    ref_o   = regs_i[REF_REG];
    fb_o    = regs_i[fb_idx];
    post_o  = post_ratio(code);
    valid_o = (code != 3'd5) && (regs_i[REF_REG] != '0);
  end
endmodule

// File: rtl/clksynth_index_port.sv
module clksynth_index_port
  import clksynth_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idx_we_i,
  input  logic [DW-1:0]      idx_i,
  input  logic               data_we_i,
  input  logic [DW-1:0]      data_i,
  output logic [DW-1:0]      data_o,
  input  logic [1:0]         vclk_sel_i,
  output logic [DW-1:0]      ref_div_o,
  output logic [DW-1:0]      fb_div_o,
  output logic [RATIO_W-1:0] post_div_o,
  output logic               div_valid_o
);
  localparam int AW = $clog2(NREG);

  logic [AW-1:0]           sel;
  logic                    wr_en;
  logic [NREG-1:0][DW-1:0] regs;

  clksynth_idx_reg #(.DW(DW), .AW(AW)) u_idx (
    .clk_i, .rst_ni, .load_i(idx_we_i), .byte_i(idx_i),
    .sel_o(sel), .wr_en_o(wr_en)
  );

  clksynth_bank #(.NREG(NREG), .DW(DW), .AW(AW)) u_bank (
    .clk_i, .rst_ni, .we_i(data_we_i & wr_en), .addr_i(sel),
    .wdata_i(data_i), .rdata_o(data_o), .regs_o(regs)
  );

  clksynth_post_decode #(.NREG(NREG), .DW(DW), .AW(AW)) u_dec (
    .regs_i(regs), .vsel_i(vclk_sel_i), .ref_o(ref_div_o),
    .fb_o(fb_div_o), .post_o(post_div_o), .valid_o(div_valid_o)
  );

  AST_VALID_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_valid_o |-> (ref_div_o != '0) && (post_div_o != '0)); // R10
  AST_RATIO_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_div_o inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12})); // R9
endmodule

// File: tb/clksynth_index_port_tb.sv
module clksynth_index_port_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       idx_we_i = 1'b0;
  logic [7:0] idx_i = '0;
  logic       data_we_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic [1:0] vclk_sel_i = '0;
  logic [7:0] ref_div_o;
  logic [7:0] fb_div_o;
  logic [3:0] post_div_o;
  logic       div_valid_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  clksynth_index_port u_dut (.*);

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic set_index(input int num, input bit wr, input bit junk);
    @(negedge clk_i);
    idx_i = {junk, 5'(num), wr, junk};
    idx_we_i = 1'b1;
    @(negedge clk_i);
    idx_we_i = 1'b0;
  endtask

  task automatic put_data(input logic [7:0] v);
    data_i = v;
    data_we_i = 1'b1;
    @(negedge clk_i);
    data_we_i = 1'b0;
  endtask

  task automatic write_reg(input int num, input logic [7:0] v);
    set_index(num, 1'b1, 1'b0);
    put_data(v);
  endtask

  function automatic int exp_ratio(input int code);
    case (code)
      0: return 1; 1: return 2; 2: return 4; 3: return 8;
      4: return 3; 6: return 6; 7: return 12;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hff);
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 valid after reset", div_valid_o, 0);
    check("R1 ref after reset", ref_div_o, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 32; i++) begin
      set_index(i, 1'b0, 1'b0);
      check($sformatf("R1 reg%0d zero", i), data_o, 0);
    end
    // R3 R6 fill and read back
    for (int i = 0; i < 32; i++) write_reg(i, pat(i));
    for (int i = 0; i < 32; i++) begin
      set_index(i, 1'b0, 1'b0);
      check($sformatf("R3 R6 reg%0d readback", i), data_o, pat(i));
    end
    // R2 junk in bits 7 and 0 ignored
    set_index(13, 1'b0, 1'b1);
    check("R2 junk bits ignored", data_o, pat(13));
    // R4 store with flag clear ignored
    set_index(20, 1'b0, 1'b0);
    put_data(8'h3c);
    check("R4 flag clear no store", data_o, pat(20));
    // R5 index loads alone change nothing
    for (int i = 0; i < 32; i++) set_index(i, 1'b1, 1'b0);
    for (int i = 0; i < 32; i++) begin
      set_index(i, 1'b0, 1'b0);
      check($sformatf("R5 reg%0d kept", i), data_o, pat(i));
    end
    // R7 R8 R9 R10 decoder sweep
    write_reg(2, 8'd9);
    for (int k = 0; k < 4; k++) write_reg(7 + k, 8'(8'h40 + k * 17));
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] r6, r11;
        r6  = (8'ha5 & ~(8'd3 << (2 * k))) | (8'(c & 3) << (2 * k));
        r11 = (8'h5a & ~(8'd1 << (4 + k))) | (8'((c >> 2) & 1) << (4 + k));
        write_reg(6, r6);
        write_reg(11, r11);
        vclk_sel_i = 2'(k);
        #1;
        check($sformatf("R8 R9 clk%0d code%0d ratio", k, c), post_div_o, exp_ratio(c));
        check($sformatf("R10 clk%0d code%0d valid", k, c), div_valid_o, (c != 5) ? 1 : 0);
        check($sformatf("R7 clk%0d fb", k), fb_div_o, 8'h40 + k * 17);
        check("R7 ref", ref_div_o, 9);
      end
    end
    // R10 zero reference divider
    write_reg(6, 8'h00);
    write_reg(11, 8'h00);
    write_reg(2, 8'h00);
    check("R10 ref zero invalid", div_valid_o, 0);
    check("R9 code0 ratio", post_div_o, 1);
    done = 1;
  end

  initial begin
    for (int n = 0; n < 100000 && !done; n++) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule